// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Path

This block is the access control and data path of a small synchronous static memory. On every rising clock edge it samples two chip enables, the address, the write controls and the write data. A selected cycle is either a write, which updates the whole word or only the chosen byte lanes of the register-built array, or a read. Read data reaches the output pins either straight from the array (flow-through) or through an extra rising-edge output register (pipeline). A static mode input selects between the two.

Output drive follows a single-cycle-deselect rule. Any captured cycle that is not a read turns the outputs off in the very next cycle, in both modes. An active-low output enable gates the drive without waiting for a clock. A sleep input stops all accesses and turns off the outputs, and the stored words are kept. The address is supplied by an external address generator, so a burst is just a run of read cycles, one per clock. The three-state pad is outside the block: it receives the data word and a drive enable, and a disabled drive stands for high impedance.

Top module: `sramPipeTop`

## Requirements
- R1: An access is selected only when chipSelN is low and chipSelHi is high in the same cycle. An unselected cycle writes nothing and gives no read.
- R2: When byteWrEnN is low and globalWrN is high, a selected cycle writes only the byte lanes whose byteSelN bit is low. Bit b covers wrData[8b+7:8b]. When byteWrEnN is high, or no byteSelN bit is low, the cycle is a read and nothing is written.
- R3: When globalWrN is low, a selected cycle writes all byte lanes, whatever byteWrEnN and byteSelN hold.
- R4: With pipeMode low (flow-through), a read presented in cycle n drives the addressed word in cycle n+1, so it is sampled at the second rising edge.
- R5: With pipeMode high (pipeline), a read presented in cycle n drives its word in cycle n+2, so it is sampled at the third rising edge. Back-to-back reads deliver one word per cycle.
- R6: A cycle that is captured as a deselect, a write or a sleep turns dataOutEn off in the next cycle in both modes. In pipeline mode, this also hides the word still held by the output register.
- R7: outEnN high forces dataOutEn low at once, with no clock edge needed.
- R8: While sleepReq is high, no write takes place, dataOutEn stays low and stored words are kept.
- R9: During and right after reset, dataOutEn is low and dataOut is zero.
- R10: A word written in cycle n is returned by a read of the same address presented in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipeMode | input | 1 | Static read path select: 0 flow-through, 1 pipeline |
| chipSelN | input | 1 | Active-low chip enable |
| chipSelHi | input | 1 | Active-high chip enable |
| addr | input | ADDR_W | Word address from the external address generator |
| byteWrEnN | input | 1 | Active-low byte-write enable |
| byteSelN | input | NUM_BYTES | Active-low per-lane write selects |
| globalWrN | input | 1 | Active-low write of all lanes |
| wrData | input | 8*NUM_BYTES | Write data |
| outEnN | input | 1 | Asynchronous active-low output enable |
| sleepReq | input | 1 | Active-high sleep request |
| dataOut | output | 8*NUM_BYTES | Read data, zero when not driven |
| dataOutEn | output | 1 | Pad drive enable; low means high impedance |

## Verification
A write lands in the array at the edge that captures it, so a read one cycle later already sees the new word. A read result is due one cycle after its capture edge in flow-through mode and two cycles after it in pipeline mode. A deselect, write or sleep removes the drive in the cycle after its capture edge. The bench model keeps its own stage variables and updates them at each rising edge. It compares drive and data at the falling edge, after the registers have settled and before the next stimulus, which is applied shortly after that falling edge. The output enable is also toggled in mid-cycle and checked one nanosecond later, with no edge in between.

// File: rtl/sramPipePkg.sv
package sramPipePkg;

  typedef struct packed {
    logic rdAccept;
    logic wrAny;
    logic globalWr;
    logic sleep;
  } sramStrobes_t;

endpackage

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPipePkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pipeMode,
  input  logic                 chipSelN,
  input  logic                 chipSelHi,
  input  logic                 byteWrEnN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 globalWrN,
  input  logic                 outEnN,
  input  logic                 sleepReq,
  output sramStrobes_t         strobes,
  output logic                 dataOutEn
);

  logic selected;
  logic anyLane;
  logic rdStage;
  logic pipeValid;

  // both enables plus no sleep make a selected cycle
  assign selected = ~chipSelN & chipSelHi & ~sleepReq;
  assign anyLane  = ~(&byteSelN);

  always_comb begin
    strobes.sleep    = sleepReq;
    strobes.globalWr = ~globalWrN;
    strobes.wrAny    = selected & (~globalWrN | (~byteWrEnN & anyLane));
    strobes.rdAccept = selected & ~strobes.wrAny;
  end

  // rdStage marks the cycle after a captured read; pipeValid one more
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage   <= 1'b0;
      pipeValid <= 1'b0;
    end else begin
      rdStage   <= strobes.rdAccept;
      pipeValid <= rdStage & ~sleepReq;
    end
  end

  // single-cycle deselect: drive needs the latest capture to be a read
  assign dataOutEn = rdStage & (pipeValid | ~pipeMode) & ~outEnN & ~sleepReq;

  a_r6_deselect_drops_drive : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdAccept |=> !dataOutEn);

endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import sramPipePkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pipeMode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_BYTES-1:0]   byteSelN,
  input  logic [8*NUM_BYTES-1:0] wrData,
  input  sramStrobes_t           strobes,
  output logic [8*NUM_BYTES-1:0] rdData
);

  localparam int WORD_W = 8 * NUM_BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0]    memArray [DEPTH];
  logic [ADDR_W-1:0]    addrReg;
  logic [WORD_W-1:0]    pipeReg;
  logic [NUM_BYTES-1:0] laneWr;

  genvar gLane;
  generate
    for (gLane = 0; gLane < NUM_BYTES; gLane++) begin : g_lane
      assign laneWr[gLane] = strobes.wrAny & (strobes.globalWr | ~byteSelN[gLane]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (laneWr[b]) memArray[addr][8*b +: 8] <= wrData[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      pipeReg <= '0;
    end else if (!strobes.sleep) begin
      addrReg <= addr;
      pipeReg <= memArray[addrReg];
    end
  end

  assign rdData = pipeMode ? pipeReg : memArray[addrReg];

  a_r8_no_write_in_sleep : assert property (@(posedge clk) disable iff (!rstN)
    strobes.sleep |-> !strobes.wrAny);

endmodule

// File: rtl/sramPipeTop.sv
module sramPipeTop
  import sramPipePkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pipeMode,
  input  logic                   chipSelN,
  input  logic                   chipSelHi,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   byteWrEnN,
  input  logic [NUM_BYTES-1:0]   byteSelN,
  input  logic                   globalWrN,
  input  logic [8*NUM_BYTES-1:0] wrData,
  input  logic                   outEnN,
  input  logic                   sleepReq,
  output logic [8*NUM_BYTES-1:0] dataOut,
  output logic                   dataOutEn
);

  sramStrobes_t          strobes;
  logic [8*NUM_BYTES-1:0] rdData;

  sramCtrl #(.NUM_BYTES(NUM_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .chipSelN(chipSelN), .chipSelHi(chipSelHi),
    .byteWrEnN(byteWrEnN), .byteSelN(byteSelN), .globalWrN(globalWrN),
    .outEnN(outEnN), .sleepReq(sleepReq),
    .strobes(strobes), .dataOutEn(dataOutEn)
  );

  sramDatapath #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) i_data (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .addr(addr),
    .byteSelN(byteSelN), .wrData(wrData), .strobes(strobes), .rdData(rdData)
  );

  assign dataOut = dataOutEn ? rdData : '0;

  always_comb begin
    if (outEnN) a_r7_oe_forces_off : assert (!dataOutEn);
  end

  a_r4_flow_read_drives : assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && strobes.rdAccept) |=> (outEnN || sleepReq || dataOutEn));

endmodule

// File: tb/test_sramPipeTop.sv
module test_sramPipeTop;
  localparam int ADDR_W = 4;
  localparam int NB     = 2;
  localparam int W      = 8 * NB;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeMode = 1'b0;
  logic chipSelN = 1'b1, chipSelHi = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic byteWrEnN = 1'b1;
  logic [NB-1:0] byteSelN = '1;
  logic globalWrN = 1'b1;
  logic [W-1:0] wrData = '0;
  logic outEnN = 1'b0, sleepReq = 1'b0;
  logic [W-1:0] dataOut;
  logic dataOutEn;

  int tests = 0, fails = 0;
  string curReq = "R9";
  bit checking = 1'b0;
  bit finished = 1'b0;

  // reference model state
  logic [W-1:0] mMem [DEPTH];
  logic mRd1 = 1'b0, mPipeV = 1'b0;
  logic [ADDR_W-1:0] mAddr1 = '0;
  logic [W-1:0] mPipe = '0;

  sramPipeTop #(.ADDR_W(ADDR_W), .NUM_BYTES(NB)) i_sramPipeTop (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .chipSelN(chipSelN),
    .chipSelHi(chipSelHi), .addr(addr), .byteWrEnN(byteWrEnN),
    .byteSelN(byteSelN), .globalWrN(globalWrN), .wrData(wrData),
    .outEnN(outEnN), .sleepReq(sleepReq), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mRd1 = 1'b0; mPipeV = 1'b0; mPipe = '0; mAddr1 = '0;
    end else if (sleepReq) begin
      mRd1 = 1'b0; mPipeV = 1'b0;
    end else begin
      logic sel, wr;
      sel = !chipSelN && chipSelHi;
      wr  = sel && (!globalWrN || (!byteWrEnN && byteSelN != '1));
      mPipe  = mMem[mAddr1];
      mPipeV = mRd1;
      if (wr) begin
        for (int b = 0; b < NB; b++)
          if (!globalWrN || !byteSelN[b]) mMem[addr][8*b +: 8] = wrData[8*b +: 8];
      end
      mRd1 = sel && !wr;
      mAddr1 = addr;
    end
  end

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareNow();
    logic expEn;
    logic [W-1:0] expData;
    expEn = !sleepReq && !outEnN && mRd1 && (pipeMode ? mPipeV : 1'b1);
    expData = pipeMode ? mPipe : mMem[mAddr1];
    check(curReq, "dataOutEn", W'(dataOutEn), W'(expEn));
    if (expEn) check(curReq, "dataOut", dataOut, expData);
  endtask

  always @(negedge clk) if (checking && rstN) compareNow();

  task automatic step(logic csN, logic csHi, logic bweN, logic [NB-1:0] bsel,
                      logic gwN, logic [ADDR_W-1:0] a, logic [W-1:0] d);
    chipSelN = csN; chipSelHi = csHi; byteWrEnN = bweN; byteSelN = bsel;
    globalWrN = gwN; addr = a; wrData = d;
    @(negedge clk); #2;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);  step(0, 1, 1, '1, 1, a, '0); endtask
  task automatic gw(logic [ADDR_W-1:0] a, logic [W-1:0] d); step(0, 1, 1, '1, 0, a, d); endtask
  task automatic idle(); step(1, 0, 1, '1, 1, '0, '0); endtask

  task automatic doReset(logic mode);
    checking = 1'b0;
    rstN = 1'b0; pipeMode = mode;
    idle(); idle();
    curReq = "R9";
    check("R9", "dataOutEn in reset", W'(dataOutEn), '0);
    check("R9", "dataOut in reset", dataOut, '0);
    rstN = 1'b1;
    idle();
    check("R9", "dataOutEn after reset", W'(dataOutEn), '0);
    checking = 1'b1;
  endtask

  task automatic commonReads();
    curReq = "R6";                       // read, deselect, read, write, read
    rd(4'd1); idle(); rd(4'd2); gw(4'd9, 16'h0909); rd(4'd9); rd(4'd3); idle(); idle();
    curReq = "R7";                       // async output enable
    rd(4'd5); rd(4'd6); rd(4'd7);
    #3 outEnN = 1'b1; #1;
    check("R7", "dataOutEn async off", W'(dataOutEn), '0);
    #2 outEnN = 1'b0; #1;
    compareNow();
    #1; idle(); idle(); idle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    #2;
    doReset(1'b0);
    for (int i = 0; i < DEPTH; i++) i_sramPipeTop.i_data.memArray[i] = '0;
    curReq = "R3";                       // global write overrides byte controls
    for (int i = 0; i < DEPTH; i++) step(0, 1, i % 2, 2'(i), 0, 4'(i), 16'hA500 + 16'(i * 17));
    curReq = "R4";                       // flow-through burst
    for (int i = 0; i < DEPTH; i++) rd(4'(i));
    idle();
    curReq = "R2";                       // byte lanes
    step(0, 1, 0, 2'b10, 1, 4'd2, 16'h1234); rd(4'd2);
    step(0, 1, 0, 2'b01, 1, 4'd3, 16'h5678); rd(4'd3);
    step(1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 4'd4, 16'hDEAD); rd(4'd4);   // enable off: read
    step(0, 1, 0, 2'b11, 1, 4'd5, 16'hBEEF); rd(4'd5);               // no lane: read
    curReq = "R1";                       // chip enables
    step(1, 1, 1, '1, 0, 4'd6, 16'hFFFF); step(0, 0, 1, '1, 0, 4'd6, 16'hFFFF);
    step(0, 0, 1, '1, 1, 4'd6, '0); rd(4'd6); idle();
    curReq = "R10";                      // write then read
    gw(4'd7, 16'h7777); rd(4'd7); gw(4'd8, 16'h8888); rd(4'd8); idle();
    commonReads();
    curReq = "R8";                       // sleep
    rd(4'd1); sleepReq = 1'b1; gw(4'd1, 16'h0BAD); gw(4'd2, 16'h0BAD); rd(4'd1);
    sleepReq = 1'b0; rd(4'd1); rd(4'd2); idle(); idle();

    doReset(1'b1);
    curReq = "R5";                       // pipeline burst
    for (int i = 0; i < DEPTH; i++) rd(4'(i));
    idle(); idle();
    curReq = "R10";
    gw(4'd10, 16'hAAAA); rd(4'd10); rd(4'd10); idle(); idle();
    commonReads();
    curReq = "R8";
    rd(4'd3); rd(4'd3); sleepReq = 1'b1; gw(4'd3, 16'h0BAD); rd(4'd3);
    sleepReq = 1'b0; rd(4'd3); rd(4'd3); idle(); idle();
    checking = 1'b0;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule